// File: doc/BRIEF.md
# Command Queue Slot Status Unit

This unit keeps count of how many entries of a graphics command queue are occupied and reports the free space through memory-mapped status reads. Host writes aimed at the queued command registers each take one slot. The write is dropped when every slot is already taken. Reads of the status register or the mode-control register each give back one slot, which models the drawing engine consuming queued work. The queue depth is fixed at build time to 8 or 16 slots.

The read data depends on the register selected and on the access width. A byte status read, a halfword or word status read, a mode-control read and a mode-control upper-byte read each place the free count, an idle flag and constant marker bits at their own positions. The drawing engine supplies a busy level. The surrounding status register supplies its current bits. On halfword and word status reads the unit raises one-cycle set pulses for the queue-empty and engine-empty interrupt flags. Read data and pulses are registered and appear one cycle after the read strobe.

Top module: `cmd_slot_status`

## Requirements
- R1: The occupied count resets to zero. The free count, equal to DEPTH minus the occupied count, never drops below zero. DEPTH is 8 or 16. After reset `rd_data_o`, `fifo_empty_set_o` and `eng_empty_set_o` are zero.
- R2: A queued write (`wr_en_i`) that arrives while all DEPTH slots are occupied is discarded, and the occupied count stays at DEPTH.
- R3: A queued write that is accepted raises the occupied count by one.
- R4: A byte status read (`rd_sel_i`=0, `rd_size_i`=0) returns 0xC0 OR the free count. Bit 5 is also set when the engine is idle and the count before the read was zero.
- R5: A halfword (`rd_size_i`=1) or word (`rd_size_i`=2) status read returns 0xC000 OR (free << 8) OR the status input bits in [7:0] OR the flag bits raised by this read. Bit 13 is set when the engine is idle and the count before the read was zero.
- R6: Status reads and mode-control reads (`rd_sel_i`=1) lower a nonzero occupied count by one. The returned free count is taken after that decrement.
- R7: A mode-control read returns the 6 control bits OR (free << 6). At byte width the result is cut to 8 bits; at halfword and word width it is not.
- R8: A mode-control upper-byte read (`rd_sel_i`=2) returns free >> 2 and leaves the count unchanged. An undecoded select (`rd_sel_i`=3) returns zero and leaves the count unchanged.
- R9: A halfword status read with a count of zero pulses `fifo_empty_set_o` and ORs bit 2 into the data, whatever the busy level. A word status read pulses `fifo_empty_set_o` (bit 2) and `eng_empty_set_o` (bit 3) only when idle with a count of zero. Byte reads pulse neither.
- R10: When a read and a queued write occur in the same cycle, the read is served first (data, idle flag, decrement) and the write is then judged against the decremented count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Queued command write strobe |
| rd_en_i | input | 1 | Register read strobe |
| rd_sel_i | input | 2 | 0 status, 1 mode control, 2 mode control upper byte, 3 none |
| rd_size_i | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| eng_busy_i | input | 1 | Drawing engine busy level |
| ctl_bits_i | input | CTL_W | Mode-control register low bits |
| sub_stat_i | input | SUB_W | Current subsystem status bits |
| rd_data_o | output | 32 | Read data, valid the cycle after rd_en_i |
| fifo_empty_set_o | output | 1 | Set pulse for the queue-empty flag |
| eng_empty_set_o | output | 1 | Set pulse for the engine-empty flag |

## Verification
The occupied count updates on the clock edge that samples a strobe. Read data and set pulses are registered on that same edge, so each result is due exactly one cycle after its strobe. Each bench task drives on a falling edge and holds the strobe through one rising edge. It then compares outputs on the next falling edge, where the registered values are stable. Queue state is observed only through later reads, and the bench expects those reads to reflect every earlier drain.

// File: rtl/cmd_slot_pkg.sv
package cmd_slot_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS  = 2'd0,
    SEL_CTL     = 2'd1,
    SEL_CTL_HI  = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD2 = 2'd3
  } acc_size_e;

  localparam int unsigned DATA_W        = 32;
  localparam int unsigned FIFO_EMPTY_BIT = 2;
  localparam int unsigned ENG_EMPTY_BIT  = 3;
  localparam int unsigned IDLE_BYTE_BIT  = 5;
  localparam int unsigned IDLE_WIDE_BIT  = 13;
  localparam int unsigned FREE_WIDE_POS  = 8;
  localparam int unsigned FREE_CTL_POS   = 6;
endpackage

// File: rtl/slot_counter.sv
module slot_counter #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          drain_i,
  input  logic          wr_i,
  output logic [CW-1:0] occ_o,
  output logic [CW-1:0] occ_dec_o
);
  logic [CW-1:0] occ_q;
  logic          accept;

  // read is served before the write
  assign occ_dec_o = (drain_i && occ_q != '0) ? occ_q - CW'(1) : occ_q;
  assign accept    = wr_i && (occ_dec_o < CW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else         occ_q <= accept ? occ_dec_o + CW'(1) : occ_dec_o;
  end

  assign occ_o = occ_q;
endmodule

// File: rtl/status_fmt.sv
module status_fmt
  import cmd_slot_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CTL_W = 6,
  parameter int unsigned SUB_W = 8,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic [1:0]        sel_i,
  input  logic [1:0]        size_i,
  input  logic [CW-1:0]     occ_i,
  input  logic [CW-1:0]     occ_dec_i,
  input  logic              busy_i,
  input  logic [CTL_W-1:0]  ctl_i,
  input  logic [SUB_W-1:0]  sub_i,
  output logic [DATA_W-1:0] data_o,
  output logic              fe_o,
  output logic              ee_o
);
  logic [DATA_W-1:0] free_w;
  logic [DATA_W-1:0] ctl_w;
  logic              idle;
  reg_sel_e          sel;
  acc_size_e         size;

  assign sel    = reg_sel_e'(sel_i);
  assign size   = acc_size_e'(size_i);
  assign free_w = DATA_W'(CW'(DEPTH) - occ_dec_i);
  assign ctl_w  = DATA_W'(ctl_i);
  assign idle   = !busy_i && (occ_i == '0);

  always_comb begin
    data_o = '0;
    fe_o   = 1'b0;
    ee_o   = 1'b0;
    unique case (sel)
      SEL_STATUS: begin
        if (size == SZ_BYTE) begin
          data_o = 32'h0000_00C0 | free_w;
          data_o[IDLE_BYTE_BIT] = idle;
        end else begin
          if (size == SZ_HALF) fe_o = (occ_i == '0);
          else begin
            fe_o = idle;
            ee_o = idle;
          end
          data_o = 32'h0000_C000 | (free_w << FREE_WIDE_POS) | DATA_W'(sub_i);
          data_o[IDLE_WIDE_BIT] = idle;
          if (fe_o) data_o[FIFO_EMPTY_BIT] = 1'b1;
          if (ee_o) data_o[ENG_EMPTY_BIT]  = 1'b1;
        end
      end
      SEL_CTL: begin
        data_o = ctl_w | (free_w << FREE_CTL_POS);
        if (size == SZ_BYTE) data_o = data_o & 32'h0000_00FF;
      end
      SEL_CTL_HI: data_o = free_w >> 2;
      default:    data_o = '0;
    endcase
  end
endmodule

// File: rtl/cmd_slot_status.sv
module cmd_slot_status
  import cmd_slot_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CTL_W = 6,
  parameter int unsigned SUB_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        rd_sel_i,
  input  logic [1:0]        rd_size_i,
  input  logic              eng_busy_i,
  input  logic [CTL_W-1:0]  ctl_bits_i,
  input  logic [SUB_W-1:0]  sub_stat_i,
  output logic [31:0]       rd_data_o,
  output logic              fifo_empty_set_o,
  output logic              eng_empty_set_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0]     occ_q;
  logic [CW-1:0]     occ_dec;
  logic              drain;
  logic [DATA_W-1:0] fmt_data;
  logic              fmt_fe, fmt_ee;

  generate
    if (DEPTH != 8 && DEPTH != 16) begin : g_bad_depth
      initial $error("cmd_slot_status: DEPTH must be 8 or 16");
    end
  endgenerate

  assign drain = rd_en_i && (rd_sel_i == SEL_STATUS || rd_sel_i == SEL_CTL);

  slot_counter #(.DEPTH(DEPTH)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .drain_i   (drain),
    .wr_i      (wr_en_i),
    .occ_o     (occ_q),
    .occ_dec_o (occ_dec)
  );

  status_fmt #(.DEPTH(DEPTH), .CTL_W(CTL_W), .SUB_W(SUB_W)) u_fmt (
    .sel_i     (rd_sel_i),
    .size_i    (rd_size_i),
    .occ_i     (occ_q),
    .occ_dec_i (occ_dec),
    .busy_i    (eng_busy_i),
    .ctl_i     (ctl_bits_i),
    .sub_i     (sub_stat_i),
    .data_o    (fmt_data),
    .fe_o      (fmt_fe),
    .ee_o      (fmt_ee)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o        <= '0;
      fifo_empty_set_o <= 1'b0;
      eng_empty_set_o  <= 1'b0;
    end else begin
      fifo_empty_set_o <= rd_en_i && fmt_fe;
      eng_empty_set_o  <= rd_en_i && fmt_ee;
      if (rd_en_i) rd_data_o <= fmt_data;
    end
  end
endmodule

// File: rtl/cmd_slot_status_chk.sv
module cmd_slot_status_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic [1:0]    rd_sel_i,
  input logic [1:0]    rd_size_i,
  input logic [31:0]   rd_data_o,
  input logic          fifo_empty_set_o,
  input logic          eng_empty_set_o,
  input logic [CW-1:0] occ_q
);
  logic drn;
  assign drn = rd_en_i && (rd_sel_i == 2'd0 || rd_sel_i == 2'd1);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= CW'(DEPTH)); // R1
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !drn && occ_q == CW'(DEPTH)) |=> occ_q == CW'(DEPTH)); // R2
  AST_WR_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !drn && occ_q < CW'(DEPTH)) |=> occ_q == $past(occ_q) + CW'(1)); // R3
  AST_BYTE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_sel_i == 2'd0 && rd_size_i == 2'd0) |=> rd_data_o[7:6] == 2'b11); // R4
  AST_RD_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drn && !wr_en_i && occ_q != '0) |=> occ_q == $past(occ_q) - CW'(1)); // R6
  AST_HI_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_sel_i[1] && !wr_en_i) |=> $stable(occ_q)); // R8
  AST_BYTE_NOSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_size_i == 2'd0) |=> !fifo_empty_set_o && !eng_empty_set_o); // R9
endmodule

bind cmd_slot_status cmd_slot_status_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .wr_en_i          (wr_en_i),
  .rd_en_i          (rd_en_i),
  .rd_sel_i         (rd_sel_i),
  .rd_size_i        (rd_size_i),
  .rd_data_o        (rd_data_o),
  .fifo_empty_set_o (fifo_empty_set_o),
  .eng_empty_set_o  (eng_empty_set_o),
  .occ_q            (occ_q)
);

// File: tb/cmd_slot_status_bench.sv
`timescale 1ns/1ps
module cmd_slot_status_bench;
  localparam int unsigned DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, busy = 1'b0;
  logic [1:0]  sel = 2'd0, size = 2'd0;
  logic [5:0]  ctl = 6'h2A;
  logic [7:0]  sub = 8'h00;
  logic [31:0] rdata;
  logic        fe_set, ee_set;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  cmd_slot_status #(.DEPTH(DEPTH)) u_cmd_slot_status (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .rd_sel_i(sel), .rd_size_i(size), .eng_busy_i(busy),
    .ctl_bits_i(ctl), .sub_stat_i(sub), .rd_data_o(rdata),
    .fifo_empty_set_o(fe_set), .eng_empty_set_o(ee_set)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic r, input logic [1:0] s, input logic [1:0] z);
    @(negedge clk);
    wr_en = w; rd_en = r; sel = s; size = z;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic t_reset;
    chk("R1 reset data", rdata, 32'h0);
    chk("R1 reset pulses", {30'd0, fe_set, ee_set}, 32'h0);
    op(0, 1, 2'd2, 2'd0);
    chk("R8 hi byte empty", rdata, 32'h04);
    busy = 0;
    op(0, 1, 2'd0, 2'd0);
    chk("R4 byte idle", rdata, 32'hF0);
  endtask

  task automatic t_fill_drop;
    for (int i = 0; i < DEPTH + 3; i++) op(1, 0, 2'd0, 2'd0);
    op(0, 1, 2'd2, 2'd0);
    chk("R2 full hi byte", rdata, 32'h00);
    op(0, 1, 2'd2, 2'd0);
    chk("R8 hi no drain", rdata, 32'h00);
    op(0, 1, 2'd3, 2'd2);
    chk("R8 undecoded zero", rdata, 32'h00);
    op(0, 1, 2'd0, 2'd0);
    chk("R6 byte after full", rdata, 32'hC1);
  endtask

  task automatic t_ctl_reads;
    op(0, 1, 2'd1, 2'd1);
    chk("R7 ctl half", rdata, 32'hAA);
    op(0, 1, 2'd1, 2'd0);
    chk("R7 ctl byte", rdata, 32'hEA);
    busy = 1;
    op(0, 1, 2'd0, 2'd1);
    chk("R5 half busy", rdata, 32'hC400);
    chk("R9 half nonempty", {30'd0, fe_set, ee_set}, 32'h0);
    op(0, 1, 2'd1, 2'd0);
    chk("R7 ctl byte trunc", rdata, 32'h6A);
    op(0, 1, 2'd1, 2'd2);
    chk("R7 ctl word", rdata, 32'h1AA);
    for (int i = 0; i < 10; i++) op(0, 1, 2'd0, 2'd0);
    op(0, 1, 2'd2, 2'd0);
    chk("R6 drained hi", rdata, 32'h04);
  endtask

  task automatic t_flags;
    sub = 8'h80;
    busy = 0;
    op(0, 1, 2'd0, 2'd1);
    chk("R5 half idle", rdata, 32'hF084);
    chk("R9 half pulses", {30'd0, fe_set, ee_set}, 32'h2);
    busy = 1;
    op(0, 1, 2'd0, 2'd2);
    chk("R5 word busy", rdata, 32'hD080);
    chk("R9 word busy pulses", {30'd0, fe_set, ee_set}, 32'h0);
    op(0, 1, 2'd0, 2'd1);
    chk("R9 half busy empty", rdata, 32'hD084);
    chk("R9 half busy pulse", {30'd0, fe_set, ee_set}, 32'h2);
    busy = 0;
    op(0, 1, 2'd0, 2'd2);
    chk("R9 word idle", rdata, 32'hF08C);
    chk("R9 word idle pulses", {30'd0, fe_set, ee_set}, 32'h3);
    op(0, 1, 2'd0, 2'd0);
    chk("R9 byte no pulse", {30'd0, fe_set, ee_set}, 32'h0);
    sub = 8'h00;
  endtask

  task automatic t_same_cycle;
    op(1, 1, 2'd0, 2'd0);
    chk("R10 read before write", rdata, 32'hF0);
    op(0, 1, 2'd0, 2'd0);
    chk("R10 write kept", rdata, 32'hD0);
    for (int i = 0; i < DEPTH; i++) op(1, 0, 2'd0, 2'd0);
    op(1, 1, 2'd0, 2'd0);
    chk("R10 full read+write", rdata, 32'hC1);
    op(0, 1, 2'd2, 2'd0);
    chk("R3 write after drain", rdata, 32'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fill_drop();
    t_ctl_reads();
    t_flags();
    t_same_cycle();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule